// File: doc/BRIEF.md
# Power Stage Fault Protection Controller

This block is the digital fault manager for an output stage built from four half-bridges. Its inputs are the overcurrent comparator flags of every power FET, a digitized junction temperature in whole degrees Celsius and the undervoltage flags of all supplies. From these it decides whether the stage keeps switching, limits current, or has every half-bridge forced to high impedance.

A single overcurrent only enables per-bridge cycle-by-cycle limiting. When limiting is seen in 16 PWM periods in a row, the block latches a shutdown that covers every bridge. The latch releases after one full PWM period with no overcurrent. Temperature is handled at two levels. A warning has its own hysteresis, and a thermal shutdown has a wider hysteresis and recovers by itself. Any supply undervoltage forces high impedance at once. An active-low fault pin follows the live fault state. A status byte holds a sticky fault bit that software clears by writing zero.

Top module: `pwr_fault_ctrl`

## Requirements
- R1: One clock after either FET flag of half-bridge h is high, `lim_hb[h]` is high; no other bit of `lim_hb` rises. A single limited PWM period does not change `hb_hiz`.
- R2: A PWM period is limited when any overcurrent flag was high during it; the boundary is marked by `pwm_start`. When 16 limited periods follow each other, all bits of `hb_hiz` go high. After 15, none do.
- R3: The overcurrent shutdown stays latched while periods stay limited. It clears at the end of the first period with no overcurrent. Such a clean period also restarts the count of R2 from zero.
- R4: `otw` rises one clock after the temperature exceeds 125 and falls one clock after it is below 100. Between those values it holds.
- R5: A temperature above 150 forces all of `hb_hiz` high two clocks later. The shutdown holds down to 120 and clears two clocks after the temperature drops below 120. A temperature of exactly 150 causes no shutdown.
- R6: Any bit of `uv_flags` high forces all of `hb_hiz` high two clocks later. Outputs return once all flags are low.
- R7: `fault_n` is low exactly when `hb_hiz` is all ones, and `hb_hiz` is always all zeros or all ones. `fault_n` deasserts as soon as no fault source is active.
- R8: Status bit 1 (sticky) sets whenever a fault is active. It clears only on a write (`sts_wr` high with `sts_wbit` low) at a time when no fault is active. A write while a fault is active, or a write of one, leaves it unchanged.
- R9: After reset `fault_n`=1, `hb_hiz`=0, `lim_hb`=0, `otw`=0 and `sts`=0.
- R10: `sts` bit 0 is the live fault, bit 2 the warning, bit 3 the thermal shutdown, bit 4 the overcurrent shutdown and bit 5 undervoltage. Bits 7:6 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_start | input | 1 | One-clock pulse at each PWM period boundary |
| oc_flags | input | 8 | Overcurrent flags, bits 2h and 2h+1 belong to half-bridge h |
| temp_c | input | 8 | Junction temperature, unsigned degrees Celsius |
| uv_flags | input | 5 | Undervoltage flags: analog supply and four power supplies |
| sts_wr | input | 1 | Status write strobe |
| sts_wbit | input | 1 | Value written to the sticky fault bit |
| lim_hb | output | 4 | Per-bridge cycle-by-cycle current limit |
| hb_hiz | output | 4 | Per-bridge high-impedance command |
| fault_n | output | 1 | Active-low fault |
| otw | output | 1 | Over-temperature warning |
| sts | output | 8 | Status byte |

## Verification
Overcurrent is applied as runs of 15 and 16 limited periods. This separates a counter that is off by one from a correct one. A run broken by one clean period shows whether the count restarts or only pauses. Temperatures are stepped onto 100, 120, 125 and 150 and just across them, approaching from both sides, to tell the set thresholds from the clear thresholds of each hysteresis loop. Random periods then mix overcurrent, temperatures in the 95 to 160 band, undervoltage and sticky-bit clears. This shows whether the three fault sources combine correctly and whether the sticky bit respects the rule that a clear is refused while a fault is active.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // status byte field positions
  localparam int STS_LIVE   = 0;
  localparam int STS_STICKY = 1;
  localparam int STS_WARN   = 2;
  localparam int STS_OTS    = 3;
  localparam int STS_OCSD   = 4;
  localparam int STS_UV     = 5;
  localparam int STS_W      = 8;
endpackage

// File: rtl/pfc_oc_guard.sv
module pfc_oc_guard #(
  parameter int NUM_HB  = 4,
  parameter int PERSIST = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwm_start,
  input  logic [2*NUM_HB-1:0] oc_flags,
  output logic [NUM_HB-1:0]   lim_hb,
  output logic                oc_shut
);
  localparam int CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] CMAX = CW'(PERSIST);

  logic          seen_q;
  logic [CW-1:0] run_q;
  logic          any_oc;
  logic          hit;

  assign any_oc = |oc_flags;
  assign hit    = seen_q | any_oc;

  // per-bridge cycle-by-cycle limiting
  for (genvar h = 0; h < NUM_HB; h++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) lim_hb[h] <= 1'b0;
      else     lim_hb[h] <= |oc_flags[2*h +: 2];
    end
  end

  // persistence counter over PWM periods
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      run_q   <= '0;
      oc_shut <= 1'b0;
    end else if (pwm_start) begin
      seen_q <= 1'b0;
      if (hit) begin
        if (run_q != CMAX) run_q <= run_q + 1'b1;
        if (run_q >= CMAX - 1'b1) oc_shut <= 1'b1;
      end else begin
        run_q   <= '0;
        oc_shut <= 1'b0;
      end
    end else begin
      seen_q <= hit;
    end
  end
endmodule

// File: rtl/pfc_hyst_cmp.sv
module pfc_hyst_cmp #(
  parameter int TEMP_W = 8,
  parameter int SET_T  = 125,
  parameter int HYST_T = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              flag
);
  localparam logic [TEMP_W-1:0] SET_V = TEMP_W'(SET_T);
  localparam logic [TEMP_W-1:0] CLR_V = TEMP_W'(SET_T - HYST_T);

  always_ff @(posedge clk) begin
    if (rst)                 flag <= 1'b0;
    else if (temp_c > SET_V) flag <= 1'b1;
    else if (temp_c < CLR_V) flag <= 1'b0;
  end
endmodule

// File: rtl/pwr_fault_ctrl.sv
module pwr_fault_ctrl
  import pfc_pkg::*;
#(
  parameter int NUM_HB    = 4,
  parameter int NUM_SUP   = 5,
  parameter int TEMP_W    = 8,
  parameter int PERSIST   = 16,
  parameter int WARN_SET  = 125,
  parameter int WARN_HYST = 25,
  parameter int SD_SET    = 150,
  parameter int SD_HYST   = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwm_start,
  input  logic [2*NUM_HB-1:0] oc_flags,
  input  logic [TEMP_W-1:0]   temp_c,
  input  logic [NUM_SUP-1:0]  uv_flags,
  input  logic                sts_wr,
  input  logic                sts_wbit,
  output logic [NUM_HB-1:0]   lim_hb,
  output logic [NUM_HB-1:0]   hb_hiz,
  output logic                fault_n,
  output logic                otw,
  output logic [STS_W-1:0]    sts
);
  logic oc_shut;
  logic ots;
  logic uv_q;
  logic fault_now;
  logic sticky_q;

  pfc_oc_guard #(.NUM_HB(NUM_HB), .PERSIST(PERSIST)) oc_i (
    .clk(clk), .rst(rst), .pwm_start(pwm_start), .oc_flags(oc_flags),
    .lim_hb(lim_hb), .oc_shut(oc_shut)
  );

  pfc_hyst_cmp #(.TEMP_W(TEMP_W), .SET_T(WARN_SET), .HYST_T(WARN_HYST)) warn_i (
    .clk(clk), .rst(rst), .temp_c(temp_c), .flag(otw)
  );

  pfc_hyst_cmp #(.TEMP_W(TEMP_W), .SET_T(SD_SET), .HYST_T(SD_HYST)) sd_i (
    .clk(clk), .rst(rst), .temp_c(temp_c), .flag(ots)
  );

  always_ff @(posedge clk) begin
    if (rst) uv_q <= 1'b0;
    else     uv_q <= |uv_flags;
  end

  assign fault_now = oc_shut | ots | uv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_hiz   <= '0;
      fault_n  <= 1'b1;
      sticky_q <= 1'b0;
      sts      <= '0;
    end else begin
      hb_hiz  <= {NUM_HB{fault_now}};
      fault_n <= ~fault_now;
      if (fault_now)                sticky_q <= 1'b1;
      else if (sts_wr && !sts_wbit) sticky_q <= 1'b0;
      sts             <= '0;
      sts[STS_LIVE]   <= fault_now;
      sts[STS_STICKY] <= fault_now | (sticky_q & ~(sts_wr & ~sts_wbit));
      sts[STS_WARN]   <= otw;
      sts[STS_OTS]    <= ots;
      sts[STS_OCSD]   <= oc_shut;
      sts[STS_UV]     <= uv_q;
    end
  end
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
  parameter int NUM_HB   = 4,
  parameter int NUM_SUP  = 5,
  parameter int TEMP_W   = 8,
  parameter int WARN_SET = 125,
  parameter int WARN_HYST = 25,
  parameter int SD_SET   = 150
) (
  input logic                clk,
  input logic                rst,
  input logic [2*NUM_HB-1:0] oc_flags,
  input logic [TEMP_W-1:0]   temp_c,
  input logic [NUM_SUP-1:0]  uv_flags,
  input logic                sts_wr,
  input logic                sts_wbit,
  input logic [NUM_HB-1:0]   lim_hb,
  input logic [NUM_HB-1:0]   hb_hiz,
  input logic                fault_n,
  input logic                otw,
  input logic [7:0]          sts
);
  // R1
  limit_b0_chk: assert property (@(posedge clk) disable iff (rst)
    (|oc_flags[1:0]) |=> lim_hb[0]);
  // R4
  warn_set_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_c > TEMP_W'(WARN_SET)) |=> otw);
  // R4
  warn_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_c < TEMP_W'(WARN_SET - WARN_HYST)) |=> !otw);
  // R5
  ots_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_c > TEMP_W'(SD_SET)) |=> ##1 (&hb_hiz));
  // R6
  uv_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (|uv_flags) |=> ##1 (&hb_hiz && !fault_n));
  // R7
  all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
    (hb_hiz == '0 || &hb_hiz) && ((&hb_hiz) == !fault_n));
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> sts[1]);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sts[1] && !(sts_wr && !sts_wbit)) |=> sts[1]);
endmodule

bind pwr_fault_ctrl pfc_chk #(
  .NUM_HB(NUM_HB), .NUM_SUP(NUM_SUP), .TEMP_W(TEMP_W),
  .WARN_SET(WARN_SET), .WARN_HYST(WARN_HYST), .SD_SET(SD_SET)
) chk_i (
  .clk(clk), .rst(rst), .oc_flags(oc_flags), .temp_c(temp_c),
  .uv_flags(uv_flags), .sts_wr(sts_wr), .sts_wbit(sts_wbit),
  .lim_hb(lim_hb), .hb_hiz(hb_hiz), .fault_n(fault_n), .otw(otw), .sts(sts)
);

// File: tb/pwr_fault_ctrl_tb_top.sv
module pwr_fault_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_start = 1'b0;
  logic [7:0] oc_flags = '0;
  logic [7:0] temp_c = 8'd25;
  logic [4:0] uv_flags = '0;
  logic       sts_wr = 1'b0;
  logic       sts_wbit = 1'b0;
  logic [3:0] lim_hb;
  logic [3:0] hb_hiz;
  logic       fault_n;
  logic       otw;
  logic [7:0] sts;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int  m_run;
  bit  m_shut, m_otw, m_ots, m_sticky;

  always #2.5 clk = ~clk;

  pwr_fault_ctrl dut_i (
    .clk(clk), .rst(rst), .pwm_start(pwm_start), .oc_flags(oc_flags),
    .temp_c(temp_c), .uv_flags(uv_flags), .sts_wr(sts_wr), .sts_wbit(sts_wbit),
    .lim_hb(lim_hb), .hb_hiz(hb_hiz), .fault_n(fault_n), .otw(otw), .sts(sts)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one PWM period of 4 clocks; oc pattern present in its first clock
  task automatic pwm_period(input logic [7:0] oc);
    oc_flags = oc; tick(1);
    oc_flags = '0; tick(2);
    pwm_start = 1'b1; tick(1);
    pwm_start = 1'b0;
  endtask

  task automatic sts_clear();
    sts_wr = 1'b1; sts_wbit = 1'b0; tick(1);
    sts_wr = 1'b0;
  endtask

  function automatic bit hyst(input bit prev, input int t, input int set_t, input int clr_t);
    if (t > set_t) return 1'b1;
    if (t < clr_t) return 1'b0;
    return prev;
  endfunction

  function automatic logic [7:0] exp_sts(input bit uv);
    logic [7:0] s;
    bit f;
    f = m_shut | m_ots | uv;
    s = '0;
    s[0] = f; s[1] = m_sticky; s[2] = m_otw; s[3] = m_ots; s[4] = m_shut; s[5] = uv;
    return s;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R9 reset state
    chk(fault_n === 1'b1 && hb_hiz === 4'h0 && lim_hb === 4'h0, "R9 outputs",
        {fault_n, hb_hiz, lim_hb}, 9'h100);
    chk(otw === 1'b0 && sts === 8'h00, "R9 status", {otw, sts}, 0);

    // R1 per-bridge limit
    oc_flags = 8'b0000_0100; tick(1);
    chk(lim_hb === 4'b0010, "R1 bridge1 limit", lim_hb, 4'b0010);
    oc_flags = 8'b1000_0000; tick(1);
    chk(lim_hb === 4'b1000, "R1 bridge3 limit", lim_hb, 4'b1000);
    oc_flags = '0; tick(1);
    chk(lim_hb === 4'b0000, "R1 limit release", lim_hb, 0);
    pwm_start = 1'b1; tick(1); pwm_start = 1'b0; tick(2);
    chk(hb_hiz === 4'h0, "R1 no shutdown after one period", hb_hiz, 0);
    pwm_period('0);

    // R2 persistence threshold
    for (int i = 0; i < 15; i++) pwm_period(8'h01 << (i % 8));
    tick(2);
    chk(hb_hiz === 4'h0 && fault_n === 1'b1, "R2 15 periods no shutdown", hb_hiz, 0);
    pwm_period(8'h10);
    tick(2);
    chk(hb_hiz === 4'hF, "R2 16th period shutdown", hb_hiz, 4'hF);
    chk(fault_n === 1'b0, "R7 fault_n low on oc shutdown", fault_n, 0);
    chk(sts === 8'h13, "R10 status on oc shutdown", sts, 8'h13);

    // R3 latch and release
    pwm_period(8'h02); tick(2);
    chk(hb_hiz === 4'hF, "R3 latched while limited", hb_hiz, 4'hF);
    pwm_period('0); tick(2);
    chk(hb_hiz === 4'h0 && fault_n === 1'b1, "R3 clean period releases", hb_hiz, 0);
    for (int i = 0; i < 10; i++) pwm_period(8'h40);
    pwm_period('0);
    for (int i = 0; i < 10; i++) pwm_period(8'h08);
    tick(2);
    chk(hb_hiz === 4'h0, "R3 clean period restarts count", hb_hiz, 0);
    pwm_period('0);

    // R8 sticky clear with no fault
    chk(sts[1] === 1'b1, "R8 sticky kept after release", sts[1], 1);
    sts_wr = 1'b1; sts_wbit = 1'b1; tick(1); sts_wr = 1'b0; tick(1);
    chk(sts[1] === 1'b1, "R8 write of one ignored", sts[1], 1);
    sts_clear(); tick(1);
    chk(sts === 8'h00, "R8 sticky cleared", sts, 0);

    // R6 undervoltage
    uv_flags = 5'b01000; tick(2);
    chk(hb_hiz === 4'hF && fault_n === 1'b0, "R6 uv forces hiz", hb_hiz, 4'hF);
    chk(sts === 8'h23, "R10 status on uv", sts, 8'h23);
    sts_clear(); tick(1);
    chk(sts[1] === 1'b1, "R8 clear refused while fault", sts[1], 1);
    uv_flags = '0; tick(2);
    chk(hb_hiz === 4'h0 && fault_n === 1'b1, "R6 uv release", hb_hiz, 0);
    chk(sts === 8'h02, "R8 sticky survives release", sts, 8'h02);
    sts_clear(); tick(1);
    chk(sts === 8'h00, "R8 sticky cleared after uv", sts, 0);

    // R4 warning hysteresis
    temp_c = 8'd125; tick(1);
    chk(otw === 1'b0, "R4 125 no warning", otw, 0);
    temp_c = 8'd126; tick(1);
    chk(otw === 1'b1, "R4 126 warning", otw, 1);
    temp_c = 8'd100; tick(2);
    chk(otw === 1'b1, "R4 100 holds", otw, 1);
    temp_c = 8'd99; tick(1);
    chk(otw === 1'b0, "R4 99 clears", otw, 0);

    // R5 thermal shutdown hysteresis
    temp_c = 8'd150; tick(2);
    chk(hb_hiz === 4'h0, "R5 150 no shutdown", hb_hiz, 0);
    temp_c = 8'd151; tick(2);
    chk(hb_hiz === 4'hF && fault_n === 1'b0, "R5 151 shutdown", hb_hiz, 4'hF);
    chk(sts === 8'h0F, "R10 status on thermal", sts, 8'h0F);
    temp_c = 8'd120; tick(3);
    chk(hb_hiz === 4'hF, "R5 120 holds", hb_hiz, 4'hF);
    temp_c = 8'd119; tick(2);
    chk(hb_hiz === 4'h0 && fault_n === 1'b1, "R5 119 recovers", hb_hiz, 0);
    temp_c = 8'd25; tick(2);
    sts_clear(); tick(1);

    // random mix against the model
    m_run = 0; m_shut = 0; m_otw = 0; m_ots = 0; m_sticky = 0;
    for (int it = 0; it < 400; it++) begin
      logic [7:0] oc;
      bit uv, wr, f;
      int t;
      t  = 95 + int'($urandom_range(65));
      uv = ($urandom_range(9) == 0);
      oc = ($urandom_range(7) != 0) ? 8'(1 << $urandom_range(7)) : 8'h00;
      wr = ($urandom_range(2) == 0);
      temp_c   = 8'(t);
      uv_flags = uv ? 5'(1 << $urandom_range(4)) : 5'h0;
      pwm_period(oc);
      if (oc != 0) begin
        if (m_run < 16) m_run++;
        if (m_run >= 16) m_shut = 1;
      end else begin
        m_run = 0; m_shut = 0;
      end
      m_otw = hyst(m_otw, t, 125, 100);
      m_ots = hyst(m_ots, t, 150, 120);
      f = m_shut | m_ots | uv;
      if (f) m_sticky = 1;
      tick(1);
      if (wr) begin
        sts_clear();
        if (!f) m_sticky = 0;
      end else tick(1);
      tick(1);
      chk(hb_hiz === {4{f}} && fault_n === !f, "R7 random fault", {fault_n, hb_hiz}, {!f, {4{f}}});
      chk(otw === m_otw, "R4 random warning", otw, m_otw);
      chk(sts === exp_sts(uv), "R10 random status", sts, exp_sts(uv));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule